// File: doc/BRIEF.md
# Debug Command Handshake Controller

This block runs the chip side of a bit-serial debug command protocol. A host shifts an 8-bit command into the block, least significant bit first. A write command is followed by a 16-bit data word. An update strobe then starts execution against a simple register-access port. When the register side reports completion, the block raises an acknowledge. For a read, the returned word is then available to be shifted out over the next 16 shift cycles. Commands are handled strictly one at a time. A shift or update that arrives while a command is still executing is dropped and recorded in a sticky error flag.

The controller stays reachable while the processor is held in reset. It is not held idle for the whole processor reset. Instead, a short internal pulse on the rising edge of the processor reset input forces it to IDLE for a fixed number of cycles. After that pulse, commands work normally, so breakpoint registers can be written before the processor leaves reset. A separate status output tells the host that the core has entered debug mode, and that acknowledge opens the debug session.

Top module: `dbg_cmd_ctrl`

## Requirements
- R1: While and after `rst_n` is low, `state_o` is IDLE (0), and `ack`, `proto_err`, `reg_req` and `dbg_ack` are 0.
- R2: The command is shifted in LSB first, one bit per cycle with `shift_en` high. The first shift moves the block from IDLE (or ACK with no read data pending) to CMD_SHIFT (1). Command bit 7 is read (1) or write (0), bit 6 set means no data, and bits 5:0 are the register address presented on `reg_addr`.
- R3: For a write command (bits 7:6 = 00), the next 16 shifts, LSB first, go to DATA_SHIFT (2) and fill the data word. An update after all 16 enters EXECUTE (3) with `reg_req`=1, `reg_we`=1 and `reg_wdata` equal to that word.
- R4: For a read command (bits 7:6 = 10), an update after 8 command bits enters EXECUTE with `reg_we`=0. After completion, `sdo` shows `reg_rdata` bit by bit, LSB first, for the next 16 shifts, and the block stays in ACK throughout.
- R5: For a no-data command (bit 6 = 1), an update after 8 bits enters EXECUTE with `reg_we`=0. After completion there is no read window, so the next shift starts a new command.
- R6: One cycle after `reg_done` is seen in EXECUTE, the block is in ACK (4) with `ack`=1 and `reg_req`=0. `ack` stays 1 until the cycle after the first shift of the next command.
- R7: In EXECUTE, `shift_en` and `upd` are ignored: the state, address and data do not change, and `proto_err` is set.
- R8: An update that arrives before all command bits, or before all 16 write data bits, returns the block to IDLE and sets `proto_err`.
- R9: A rising edge on `cpu_rst` forces IDLE for PULSE_LEN (default 4) cycles, and shifts in that window are ignored. Afterwards, complete commands execute even though `cpu_rst` is still high.
- R10: `dbg_ack` equals `core_halted` delayed by one clock cycle.
- R11: `proto_err` stays set until `rst_n` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| cpu_rst | input | 1 | Processor reset level; its rising edge triggers the IDLE pulse |
| core_halted | input | 1 | Core is in debug mode |
| shift_en | input | 1 | Shift one bit this cycle |
| sdi | input | 1 | Serial data in |
| upd | input | 1 | Update strobe, starts execution |
| sdo | output | 1 | Serial data out (LSB of the data shifter) |
| reg_req | output | 1 | Register access request, held until done |
| reg_we | output | 1 | Access is a write |
| reg_addr | output | 6 | Register address |
| reg_wdata | output | 16 | Write data |
| reg_rdata | input | 16 | Read data, taken with reg_done |
| reg_done | input | 1 | Register access complete |
| ack | output | 1 | Command acknowledged |
| proto_err | output | 1 | Sticky protocol error |
| dbg_ack | output | 1 | Debug-mode entry acknowledge |
| state_o | output | 3 | Controller state: 0 IDLE, 1 CMD_SHIFT, 2 DATA_SHIFT, 3 EXECUTE, 4 ACK |

## Verification
The assertions assume that the register side raises `reg_done` only while `reg_req` is high, and that `shift_en` and `upd` are single-cycle inputs that do not change near the clock edge. The stimulus changes every input on the falling edge. It pulses `reg_done` for exactly one cycle, and only after it has seen EXECUTE on `state_o`. It also deliberately sends shifts and updates during EXECUTE and inside the reset pulse to exercise the paths that must ignore them.

// File: rtl/dbg_cmd_ctrl.sv
module dbg_cmd_ctrl #(
  parameter int CMD_W     = 8,
  parameter int DATA_W    = 16,
  parameter int PULSE_LEN = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_rst,
  input  logic                core_halted,
  input  logic                shift_en,
  input  logic                sdi,
  input  logic                upd,
  output logic                sdo,
  output logic                reg_req,
  output logic                reg_we,
  output logic [CMD_W-3:0]    reg_addr,
  output logic [DATA_W-1:0]   reg_wdata,
  input  logic [DATA_W-1:0]   reg_rdata,
  input  logic                reg_done,
  output logic                ack,
  output logic                proto_err,
  output logic                dbg_ack,
  output logic [2:0]          state_o
);

  localparam int ADDR_W = CMD_W - 2;
  localparam int CNT_W  = $clog2(DATA_W + 1);
  localparam int PW     = $clog2(PULSE_LEN + 1);
  localparam logic [CNT_W-1:0] CMD_N  = CNT_W'(CMD_W);
  localparam logic [CNT_W-1:0] DATA_N = CNT_W'(DATA_W);

  typedef enum logic [2:0] {
    S_IDLE = 3'd0, S_CMD = 3'd1, S_DATA = 3'd2, S_EXEC = 3'd3, S_ACK = 3'd4
  } state_t;

  state_t            state;
  logic [CMD_W-1:0]  cmd_sr;
  logic [DATA_W-1:0] data_sr;
  logic [CNT_W-1:0]  bit_cnt;
  logic [PW-1:0]     pcnt;
  logic              perr, halt_q, cpu_rst_q;

  wire is_read   = cmd_sr[CMD_W-1];
  wire no_data   = cmd_sr[CMD_W-2];
  wire has_wdata = !is_read && !no_data;
  wire has_rdata = is_read && !no_data;
  wire cmd_full  = (bit_cnt == CMD_N);
  wire data_full = (bit_cnt == DATA_N);
  wire rst_rise  = cpu_rst && !cpu_rst_q;
  wire rst_pulse = rst_rise || (pcnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cmd_sr    <= '0;
      data_sr   <= '0;
      bit_cnt   <= '0;
      pcnt      <= '0;
      perr      <= 1'b0;
      halt_q    <= 1'b0;
      cpu_rst_q <= 1'b0;
    end else begin
      cpu_rst_q <= cpu_rst;
      halt_q    <= core_halted;
      if (rst_rise)          pcnt <= PW'(PULSE_LEN - 1);
      else if (pcnt != '0)   pcnt <= pcnt - 1'b1;

      if (rst_pulse) begin
        state   <= S_IDLE;
        bit_cnt <= '0;
      end else begin
        case (state)
          S_IDLE: if (shift_en) begin
            cmd_sr  <= {sdi, cmd_sr[CMD_W-1:1]};
            bit_cnt <= CNT_W'(1);
            state   <= S_CMD;
          end
          S_CMD: if (upd) begin
            if (cmd_full && !has_wdata) state <= S_EXEC;
            else begin
              state <= S_IDLE;
              perr  <= 1'b1;
            end
          end else if (shift_en) begin
            if (!cmd_full) begin
              cmd_sr  <= {sdi, cmd_sr[CMD_W-1:1]};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (has_wdata) begin
              data_sr <= {sdi, data_sr[DATA_W-1:1]};
              bit_cnt <= CNT_W'(1);
              state   <= S_DATA;
            end
          end
          S_DATA: if (upd) begin
            if (data_full) state <= S_EXEC;
            else begin
              state <= S_IDLE;
              perr  <= 1'b1;
            end
          end else if (shift_en && !data_full) begin
            data_sr <= {sdi, data_sr[DATA_W-1:1]};
            bit_cnt <= bit_cnt + 1'b1;
          end
          S_EXEC: begin
            if (shift_en || upd) perr <= 1'b1;
            if (reg_done) begin
              state <= S_ACK;
              if (has_rdata) begin
                data_sr <= reg_rdata;
                bit_cnt <= DATA_N;
              end else begin
                bit_cnt <= '0;
              end
            end
          end
          S_ACK: if (shift_en) begin
            if (bit_cnt != '0) begin
              data_sr <= {sdi, data_sr[DATA_W-1:1]};
              bit_cnt <= bit_cnt - 1'b1;
            end else begin
              cmd_sr  <= {sdi, cmd_sr[CMD_W-1:1]};
              bit_cnt <= CNT_W'(1);
              state   <= S_CMD;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  assign sdo       = data_sr[0];
  assign reg_req   = (state == S_EXEC);
  assign reg_we    = reg_req && has_wdata;
  assign reg_addr  = cmd_sr[ADDR_W-1:0];
  assign reg_wdata = data_sr;
  assign ack       = (state == S_ACK);
  assign proto_err = perr;
  assign dbg_ack   = halt_q;
  assign state_o   = state;

endmodule

// File: rtl/dbg_cmd_ctrl_chk.sv
module dbg_cmd_ctrl_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              shift_en,
  input logic              upd,
  input logic              reg_req,
  input logic              reg_done,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              ack,
  input logic              proto_err,
  input logic [2:0]        state_o,
  input logic              rst_pulse
);

  // R6
  ack_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> $past(reg_done));

  // R7
  exec_intrusion_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd3 && (shift_en || upd) && !rst_pulse) |=> proto_err);

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

  // R9
  pulse_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |=> (state_o == 3'd0));

  // R3
  req_from_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_req) |-> $past(upd));

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && !reg_done && !rst_pulse) |=> (reg_req && $stable(reg_addr)));

endmodule

bind dbg_cmd_ctrl dbg_cmd_ctrl_chk #(.ADDR_W(CMD_W - 2)) i_chk (
  .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .upd(upd),
  .reg_req(reg_req), .reg_done(reg_done), .reg_addr(reg_addr),
  .ack(ack), .proto_err(proto_err), .state_o(state_o), .rst_pulse(rst_pulse)
);

// File: tb/test_dbg_cmd_ctrl.sv
`timescale 1ns/1ps
module test_dbg_cmd_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, cpu_rst = 1'b0, core_halted = 1'b0;
  logic shift_en = 1'b0, sdi = 1'b0, upd = 1'b0, reg_done = 1'b0;
  logic [15:0] reg_rdata = '0;
  logic sdo, reg_req, reg_we, ack, proto_err, dbg_ack;
  logic [5:0] reg_addr;
  logic [15:0] reg_wdata;
  logic [2:0] state_o;
  int checks = 0, errors = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  dbg_cmd_ctrl i_dbg_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_rst(cpu_rst), .core_halted(core_halted),
    .shift_en(shift_en), .sdi(sdi), .upd(upd), .sdo(sdo),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_done(reg_done),
    .ack(ack), .proto_err(proto_err), .dbg_ack(dbg_ack), .state_o(state_o)
  );

  // {command, write data, read data}
  localparam logic [39:0] VEC [6] = '{
    {8'h05, 16'hA5C3, 16'h0000},
    {8'h85, 16'h0000, 16'h3C5A},
    {8'h7F, 16'h0000, 16'h0000},
    {8'h3A, 16'h0001, 16'h0000},
    {8'hC2, 16'h0000, 16'hFFFF},
    {8'h80, 16'h0000, 16'h8001}
  };

  task automatic tick; @(negedge clk); endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic shift_bit(input logic b);
    shift_en = 1'b1; sdi = b; tick(); shift_en = 1'b0;
  endtask

  task automatic pulse_upd;
    upd = 1'b1; tick(); upd = 1'b0;
  endtask

  task automatic do_reset;
    rst_n = 1'b0; tick(); tick(); rst_n = 1'b1; tick();
  endtask

  task automatic run_cmd(input logic [7:0] cmd, input logic [15:0] wd, input logic [15:0] rd);
    logic wr, rdw;
    logic [15:0] got;
    wr  = !cmd[7] && !cmd[6];
    rdw = cmd[7] && !cmd[6];
    shift_bit(cmd[0]);
    chk("R2 first shift enters CMD_SHIFT", state_o, 1);
    chk("R6 ack clears on new command", ack, 0);
    for (int i = 1; i < 8; i++) shift_bit(cmd[i]);
    chk("R2 state after 8 bits", state_o, 1);
    if (wr) begin
      for (int i = 0; i < 16; i++) shift_bit(wd[i]);
      chk("R3 data shift state", state_o, 2);
    end
    pulse_upd();
    chk("R3 execute state", state_o, 3);
    chk("R2 reg_addr", reg_addr, cmd[5:0]);
    chk("R4 reg_req", reg_req, 1);
    chk("R5 reg_we", reg_we, wr);
    if (wr) chk("R3 reg_wdata", reg_wdata, wd);
    tick(); tick();
    chk("R6 waits for done", state_o, 3);
    reg_rdata = rd; reg_done = 1'b1; tick(); reg_done = 1'b0;
    chk("R6 ack state", state_o, 4);
    chk("R6 ack high", ack, 1);
    chk("R6 req released", reg_req, 0);
    if (rdw) begin
      got = '0;
      for (int i = 0; i < 16; i++) begin
        got[i] = sdo;
        shift_bit(1'b0);
      end
      chk("R4 read data on sdo", got, rd);
      chk("R4 ack held through read window", ack, 1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    chk("R1 state in reset", state_o, 0);
    rst_n = 1'b1; tick();
    chk("R1 state", state_o, 0);
    chk("R1 ack", ack, 0);
    chk("R1 proto_err", proto_err, 0);
    chk("R1 reg_req", reg_req, 0);
    chk("R1 dbg_ack", dbg_ack, 0);

    for (int v = 0; v < 6; v++) run_cmd(VEC[v][39:32], VEC[v][31:16], VEC[v][15:0]);
    chk("R11 no error after clean traffic", proto_err, 0);

    // R7: intrusion during execute
    do_reset();
    run_cmd(8'h11, 16'h1234, 16'h0000);
    for (int i = 0; i < 8; i++) shift_bit(1'b1);
    pulse_upd();
    chk("R7 still executing", state_o, 3);
    chk("R7 proto_err before intrusion", proto_err, 0);
    shift_bit(1'b0);
    chk("R7 shift ignored", state_o, 3);
    chk("R7 addr kept", reg_addr, 6'h3F);
    chk("R7 proto_err set", proto_err, 1);
    pulse_upd();
    chk("R7 update ignored", state_o, 3);
    reg_done = 1'b1; tick(); reg_done = 1'b0;
    chk("R11 error stays after ack", proto_err, 1);
    shift_bit(1'b0);
    chk("R11 error stays on new command", proto_err, 1);
    do_reset();
    chk("R11 cleared by reset", proto_err, 0);

    // R8: short command and short data
    for (int i = 0; i < 5; i++) shift_bit(1'b1);
    pulse_upd();
    chk("R8 short command to IDLE", state_o, 0);
    chk("R8 short command error", proto_err, 1);
    do_reset();
    for (int i = 0; i < 8; i++) shift_bit(i == 1);
    for (int i = 0; i < 10; i++) shift_bit(1'b1);
    pulse_upd();
    chk("R8 short data to IDLE", state_o, 0);
    chk("R8 short data error", proto_err, 1);
    do_reset();

    // R9: processor reset pulse
    for (int i = 0; i < 3; i++) shift_bit(1'b1);
    chk("R9 mid command", state_o, 1);
    cpu_rst = 1'b1; tick();
    chk("R9 pulse forces IDLE", state_o, 0);
    for (int i = 0; i < 3; i++) begin
      shift_bit(1'b1);
      chk("R9 shift ignored in pulse", state_o, 0);
    end
    run_cmd(8'h24, 16'hBEEF, 16'h0000);
    chk("R9 command works during processor reset", ack, 1);
    cpu_rst = 1'b0; tick();

    // R10: debug entry acknowledge
    core_halted = 1'b1;
    chk("R10 not yet", dbg_ack, 0);
    tick();
    chk("R10 follows halt", dbg_ack, 1);
    core_halted = 1'b0; tick();
    chk("R10 follows release", dbg_ack, 0);

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule